// File: doc/BRIEF.md
# Windowed Software Watchdog

This block supervises a processor by watching an active-low clear line. Time is counted in ticks of an external timebase, and every watchdog period is split into two phases. First comes a closed phase in which software must not clear the watchdog. It is followed by an open phase in which software must clear it. A clear in the open phase starts a fresh closed phase and produces a one-cycle "good service" strobe. If the clear comes too early, or never comes, the block raises a reset request for a fixed number of ticks and then starts a new closed phase.

The nominal period, the half-width of the open phase (as a percentage of the period) and the reset pulse length (as a divisor of the period) are parameters. The open phase is centred on the nominal period: it starts at `P - P*PCT/100` ticks and lasts `2*P*PCT/100` ticks. The clear line is synchronized, and only a low level that holds for a minimum number of samples counts as a clear. Counting is held off until a power-on controller asserts the run enable.

Top module: `wdw_supervisor`

## Requirements
- R1: While `run_en_i` is low, and directly after `rst_n` is released, `rst_req_o` and `svc_ok_o` are 0, and ticks and clears have no effect on them.
- R2: Counting begins on the first clock after `run_en_i` goes high, at the start of a closed phase. With no clear, `rst_req_o` rises on the tick that completes the closed and open phases together.
- R3: With H = P*PCT/100 (integer division), the closed phase lasts P-H ticks and the open phase lasts 2*H ticks.
- R4: A clear during the closed phase raises `rst_req_o` on the next clock and gives no `svc_ok_o` pulse.
- R5: A clear during the open phase gives exactly one `svc_ok_o` pulse of one clock, leaves `rst_req_o` at 0, and starts a new closed phase of full length.
- R6: `rst_req_o` stays high for max(1, P/DIV) ticks and then falls, starting a new closed phase.
- R7: If no clear ever arrives, `rst_req_o` repeats with a period of closed + open + pulse ticks. It is high for the last pulse-length ticks of each period.
- R8: A clear while `rst_req_o` is high is ignored. The pulse keeps its length and the next period is unchanged.
- R9: A clear counts only after the synchronized line has been low for MIN_LOW consecutive clocks. A shorter low is ignored. A held low counts once.
- R10: Dropping `run_en_i` returns the block to idle on the next clock and ends any reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick, one clock wide |
| run_en_i | input | 1 | Run enable from the power-on controller |
| clr_n_i | input | 1 | Active-low software clear, asynchronous |
| rst_req_o | output | 1 | Reset pulse request, active high |
| svc_ok_o | output | 1 | One-clock strobe for a correct service |

## Verification
The assertions assume that `tick_i` and `run_en_i` are synchronous to `clk`. They also assume that a recognized clear and a tick may coincide, in which case the clear takes precedence. The bench avoids that ambiguity: every clear is completed between two ticks, so the phase position of each clear is a known tick count. Every clear is held low for at least MIN_LOW clocks, except in the one test of a deliberately short pulse.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_CLOSED = 2'd1,
      PH_OPEN   = 2'd2,
      PH_PULSE  = 2'd3
   } wdw_phase_e;

   function automatic int unsigned wdw_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/wdw_clr_qual.sv
module wdw_clr_qual #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MIN_LOW     = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_n_in,
   output logic clr_ev
);
   logic [SYNC_STAGES-1:0] sync_sr;
   logic                   s_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_sr <= '1;
      else        sync_sr <= {sync_sr[SYNC_STAGES-2:0], clr_n_in};
   end

   assign s_low = ~sync_sr[SYNC_STAGES-1];

   generate
      if (MIN_LOW <= 1) begin : g_edge
         logic armed;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) armed <= 1'b1;
            else        armed <= ~s_low;
         end
         assign clr_ev = s_low & armed;
      end else begin : g_width
         localparam int unsigned LW = $clog2(MIN_LOW + 1);
         logic [LW-1:0] low_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   low_cnt <= '0;
            else if (!s_low)              low_cnt <= '0;
            else if (low_cnt != LW'(MIN_LOW)) low_cnt <= low_cnt + LW'(1);
         end
         assign clr_ev = s_low && (low_cnt == LW'(MIN_LOW - 1));
      end
   endgenerate

   AST_ONE_EVENT_PER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ev |=> !clr_ev); // R9
endmodule

// File: rtl/wdw_tick_cnt.sv
module wdw_tick_cnt #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);
   logic [CNT_W-1:0] cnt;
   logic             at_end;

   assign at_end = (cnt == limit - CNT_W'(1));
   assign expire = tick && !restart && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (restart) cnt <= '0;
      else if (tick) begin
         if (at_end) cnt <= '0;
         else        cnt <= cnt + CNT_W'(1);
      end
   end

   AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < limit); // R3
endmodule

// File: rtl/wdw_phase_ctl.sv
module wdw_phase_ctl
   import wdw_pkg::*;
#(
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned CLOSED_T = 80,
   parameter int unsigned OPEN_T   = 40,
   parameter int unsigned PULSE_T  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             tick,
   input  logic             clr_ev,
   input  logic             expire,
   output logic             restart,
   output logic [CNT_W-1:0] limit,
   output logic             rst_req,
   output logic             svc_ok
);
   wdw_phase_e phase, phase_nx;
   logic       svc_nx;

   always_comb begin
      phase_nx = phase;
      svc_nx   = 1'b0;
      if (!run_en) begin
         phase_nx = PH_IDLE;
      end else begin
         unique case (phase)
            PH_IDLE:   phase_nx = PH_CLOSED;
            PH_CLOSED: begin
               if (clr_ev)      phase_nx = PH_PULSE;
               else if (expire) phase_nx = PH_OPEN;
            end
            PH_OPEN: begin
               if (clr_ev) begin
                  phase_nx = PH_CLOSED;
                  svc_nx   = 1'b1;
               end else if (expire) begin
                  phase_nx = PH_PULSE;
               end
            end
            PH_PULSE: if (expire) phase_nx = PH_CLOSED;
            default:  phase_nx = PH_IDLE;
         endcase
      end
   end

   assign restart = !run_en || (phase == PH_IDLE) ||
                    (clr_ev && ((phase == PH_CLOSED) || (phase == PH_OPEN)));

   always_comb begin
      unique case (phase)
         PH_OPEN:  limit = CNT_W'(OPEN_T);
         PH_PULSE: limit = CNT_W'(PULSE_T);
         default:  limit = CNT_W'(CLOSED_T);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         svc_ok <= 1'b0;
      end else begin
         phase  <= phase_nx;
         svc_ok <= svc_nx;
      end
   end

   assign rst_req = (phase == PH_PULSE);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (!rst_req && !svc_ok)); // R1
   AST_EARLY_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && phase == PH_CLOSED && clr_ev) |=> rst_req); // R4
   AST_SVC_FROM_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      svc_ok |-> ($past(phase) == PH_OPEN)); // R5
   AST_SVC_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      svc_ok |-> (!rst_req && phase == PH_CLOSED)); // R5
   AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && rst_req && !tick) |=> rst_req); // R8
endmodule

// File: rtl/wdw_supervisor.sv
module wdw_supervisor #(
   parameter int unsigned PERIOD_TICKS = 100,
   parameter int unsigned OPEN_PCT     = 20,
   parameter int unsigned PULSE_DIV    = 40,
   parameter int unsigned MIN_LOW      = 3,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic run_en_i,
   input  logic clr_n_i,
   output logic rst_req_o,
   output logic svc_ok_o
);
   localparam int unsigned HALF_T   = PERIOD_TICKS * OPEN_PCT / 100;
   localparam int unsigned CLOSED_T = PERIOD_TICKS - HALF_T;
   localparam int unsigned OPEN_T   = 2 * HALF_T;
   localparam int unsigned PULSE_T  = wdw_pkg::wdw_max(1, PERIOD_TICKS / PULSE_DIV);
   localparam int unsigned MAX_T    = wdw_pkg::wdw_max(wdw_pkg::wdw_max(CLOSED_T, OPEN_T), PULSE_T);
   localparam int unsigned CNT_W    = $clog2(MAX_T + 1);

   generate
      if (OPEN_PCT < 1 || OPEN_PCT > 99) begin : g_bad_pct
         $error("wdw_supervisor: OPEN_PCT must lie in 1..99");
      end
      if (HALF_T < 1) begin : g_bad_half
         $error("wdw_supervisor: open window rounds to zero ticks");
      end
      if (PULSE_DIV < 1) begin : g_bad_div
         $error("wdw_supervisor: PULSE_DIV must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("wdw_supervisor: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             clr_ev;
   logic             restart;
   logic             expire;
   logic [CNT_W-1:0] limit;

   wdw_clr_qual #(
      .SYNC_STAGES (SYNC_STAGES),
      .MIN_LOW     (MIN_LOW)
   ) i_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_n_in (clr_n_i),
      .clr_ev   (clr_ev)
   );

   wdw_tick_cnt #(
      .CNT_W (CNT_W)
   ) i_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .tick    (tick_i),
      .limit   (limit),
      .expire  (expire)
   );

   wdw_phase_ctl #(
      .CNT_W    (CNT_W),
      .CLOSED_T (CLOSED_T),
      .OPEN_T   (OPEN_T),
      .PULSE_T  (PULSE_T)
   ) i_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_en  (run_en_i),
      .tick    (tick_i),
      .clr_ev  (clr_ev),
      .expire  (expire),
      .restart (restart),
      .limit   (limit),
      .rst_req (rst_req_o),
      .svc_ok  (svc_ok_o)
   );

   AST_DISABLE_ENDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req_o && !run_en_i) |=> !rst_req_o); // R10
endmodule

// File: tb/test_wdw_supervisor.sv
module test_wdw_supervisor;
   localparam int CLK_PERIOD = 10;
   localparam int P   = 20;
   localparam int PCT = 25;
   localparam int DIV = 5;
   localparam int ML  = 3;
   localparam int H   = P * PCT / 100;
   localparam int CW  = P - H;
   localparam int OW  = 2 * H;
   localparam int PW  = (P / DIV < 1) ? 1 : P / DIV;
   localparam int L   = CW + OW + PW;

   logic clk = 0, rst_n = 0, tick_i = 0, run_en_i = 0, clr_n_i = 1;
   logic rst_req_o, svc_ok_o;
   int checks = 0, errors = 0, svc_cnt = 0, rise_cnt = 0;
   logic rst_q = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdw_supervisor #(.PERIOD_TICKS(P), .OPEN_PCT(PCT), .PULSE_DIV(DIV),
                    .MIN_LOW(ML), .SYNC_STAGES(2)) i_wdw_supervisor (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_en_i(run_en_i),
      .clr_n_i(clr_n_i), .rst_req_o(rst_req_o), .svc_ok_o(svc_ok_o));

   always @(negedge clk) begin
      if (svc_ok_o) svc_cnt++;
      if (rst_req_o && !rst_q) rise_cnt++;
      rst_q = rst_req_o;
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick_i = 1;
         @(negedge clk) tick_i = 0;
         repeat (6) @(negedge clk);
      end
   endtask

   task automatic clr_pulse(input int len);
      @(negedge clk) clr_n_i = 0;
      repeat (len) @(negedge clk);
      clr_n_i = 1;
      repeat (6) @(negedge clk);
   endtask

   task automatic restart();
      @(negedge clk) run_en_i = 0; clr_n_i = 1;
      repeat (3) @(negedge clk);
      run_en_i = 1;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int s0, r0;
      repeat (5) @(negedge clk);
      chk("R1 reset rst_req", rst_req_o, 0);
      chk("R1 reset svc_ok", svc_ok_o, 0);
      rst_n = 1;
      repeat (3) @(negedge clk);

      // R1: disabled, ticks and clears have no effect
      s0 = svc_cnt; r0 = rise_cnt;
      for (int i = 0; i < 4; i++) begin
         tick_n(P);
         clr_pulse(ML + 2);
      end
      chk("R1 idle rst_req", rst_req_o, 0);
      chk("R1 idle rises", rise_cnt - r0, 0);
      chk("R1 idle svc", svc_cnt - s0, 0);

      // R2 R3 R6 R7: free-running square wave, tick by tick
      restart();
      for (int t = 1; t <= 3 * L; t++) begin
         tick_n(1);
         chk("R7 square wave level", rst_req_o, ((t % L) >= CW + OW) ? 1 : 0);
      end

      // R3 R4 R5 R6: sweep clear position over the whole period
      for (int k = 0; k < CW + OW; k++) begin
         restart();
         tick_n(k);
         s0 = svc_cnt;
         clr_pulse(ML);
         if (k < CW) begin
            chk("R4 early clear resets", rst_req_o, 1);
            chk("R4 early clear no svc", svc_cnt - s0, 0);
            tick_n(PW - 1);
            chk("R6 pulse still high", rst_req_o, 1);
            tick_n(1);
            chk("R6 pulse ended", rst_req_o, 0);
         end else begin
            chk("R5 open clear svc", svc_cnt - s0, 1);
            chk("R5 open clear no reset", rst_req_o, 0);
            tick_n(CW - 1);
            s0 = svc_cnt;
            clr_pulse(ML);
            chk("R5 new closed window full", rst_req_o, 1);
            chk("R5 new closed window no svc", svc_cnt - s0, 0);
         end
      end

      // R5 exact open boundary after a service
      restart();
      tick_n(CW);
      clr_pulse(ML);
      tick_n(CW);
      s0 = svc_cnt;
      clr_pulse(ML);
      chk("R5 second service accepted", svc_cnt - s0, 1);

      // R8: clear during the pulse is ignored
      restart();
      tick_n(CW + OW);
      chk("R8 pulse active", rst_req_o, 1);
      s0 = svc_cnt;
      clr_pulse(ML + 1);
      chk("R8 pulse kept", rst_req_o, 1);
      chk("R8 no svc", svc_cnt - s0, 0);
      tick_n(PW);
      chk("R8 pulse length unchanged", rst_req_o, 0);
      tick_n(CW + OW - 1);
      chk("R8 next period unchanged low", rst_req_o, 0);
      tick_n(1);
      chk("R8 next period unchanged high", rst_req_o, 1);

      // R9: short low ignored, long low counts once
      restart();
      tick_n(CW);
      s0 = svc_cnt;
      clr_pulse(ML - 1);
      chk("R9 short low ignored svc", svc_cnt - s0, 0);
      chk("R9 short low ignored rst", rst_req_o, 0);
      @(negedge clk) clr_n_i = 0;
      repeat (20) @(negedge clk);
      chk("R9 long low counts", svc_cnt - s0, 1);
      tick_n(CW);
      @(negedge clk) clr_n_i = 1;
      repeat (6) @(negedge clk);
      chk("R9 held low counts once", svc_cnt - s0, 1);
      chk("R9 held low no reset", rst_req_o, 0);
      clr_pulse(ML);
      chk("R9 fresh edge counts", svc_cnt - s0, 2);

      // R10: dropping the enable ends a pulse
      restart();
      tick_n(CW + OW);
      chk("R10 pulse before drop", rst_req_o, 1);
      @(negedge clk) run_en_i = 0;
      @(negedge clk);
      chk("R10 pulse cleared", rst_req_o, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule